// File: doc/BRIEF.md
# Processor Interrupt Pin Front-End

This block stands between the control pins that enter a processor and the logic in the core that holds pending interrupts. Each pin is a level that can change at any time. The block brings every pin into the clock domain through a two-flop synchroniser. It keeps the last level it acted on for each pin, and it acts only when the synchronised level differs from that recorded level. Depending on the pin, a change updates a pending-interrupt bit, sets the core halt flag, issues a one-cycle system reset request, or pulses a start or stop strobe towards the time base.

The pending bits are combined into one summary interrupt request for the core. Software acknowledges a pending bit through a one-cycle acknowledge strobe that carries the bit index. Interrupt vectoring and priority, the reset sequence itself and the time base counter are outside this block.

Pin vector layout (`pins_i`): bit 0 external interrupt, bit 1 system-management interrupt, bit 2 machine check, bit 3 checkstop, bit 4 hard reset, bit 5 soft reset, bit 6 time-base enable. Bits 7 and up are spare. Pending vector layout (`pending_o`): bit 0 external, bit 1 system-management, bit 2 machine check, bit 3 soft reset.

Top module: `pin_irq_frontend`

## Requirements
- R1: After reset, `pending_o` is 0 and `irq_req_o`, `halt_o`, `sys_reset_req_o`, `tb_start_o` and `tb_stop_o` are all 0. Every recorded pin level is 0.
- R2: The external interrupt pin (`pins_i` bit 0) and the system-management pin (bit 1) are active high. When one of them changes, its pending bit (bit 0 or bit 1 respectively) takes the new level.
- R3: The machine-check pin (bit 2) acts only on a falling change. That change sets pending bit 2. A rising change on the pin leaves pending bit 2 unchanged.
- R4: A rising change on the checkstop pin (bit 3) sets `halt_o`. Nothing except reset clears `halt_o`, including the pin falling again.
- R5: A rising change on the hard-reset pin (bit 4) raises `sys_reset_req_o` for exactly one cycle. A falling change on that pin produces no request.
- R6: When the soft-reset pin (bit 5) changes, pending bit 3 takes the new level.
- R7: A rising change on the time-base enable pin (bit 6) pulses `tb_start_o` for one cycle. A falling change pulses `tb_stop_o` for one cycle. The two strobes are never high together.
- R8: `irq_req_o` is 1 exactly when `pending_o` is not zero.
- R9: Changes on spare pins (`pins_i` bit 7 and up) affect no output.
- R10: An acknowledge (`ack_valid_i` high for one cycle, with the bit number on `ack_idx_i`) clears that pending bit on the next edge. If a pin event sets the same bit in the same cycle, the set wins.
- R11: A pin change reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| pins_i | input | PIN_W | Asynchronous pin levels, laid out as given above |
| ack_valid_i | input | 1 | One-cycle acknowledge strobe |
| ack_idx_i | input | 2 | Number of the pending bit to clear |
| pending_o | output | 4 | Pending-interrupt vector |
| irq_req_o | output | 1 | Summary interrupt request |
| halt_o | output | 1 | Core halt flag |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| tb_start_o | output | 1 | Time-base start strobe |
| tb_stop_o | output | 1 | Time-base stop strobe |

## Verification
The directed patterns cover the different kinds of pin:
- Level pins are raised and dropped singly and in overlapping pairs. This tells a pending bit that follows its pin from one that latches, and shows whether the summary request drops only once the whole vector is empty.
- The machine-check pin is taken through a rise, a fall, a second rise and a second fall. This separates falling-edge capture from level following and shows the bit is sticky.
- The checkstop, hard-reset and time-base pins are run in both directions. This tells sticky flags from single-cycle strobes and checks the polarity of each strobe.
- Spare-pin toggles and an acknowledge that collides with a set cover the ignore path and the set-wins priority.
- A sample taken one edge early pins down the latency.

// File: rtl/pinfe_pkg.sv
package pinfe_pkg;

    // positions in the pin vector
    localparam int PIN_EXT   = 0;
    localparam int PIN_SMI   = 1;
    localparam int PIN_MCK   = 2;
    localparam int PIN_CSTOP = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int PIN_TBEN  = 6;
    localparam int NUM_DEF_PINS = 7;

    // positions in the pending vector
    localparam int PEND_EXT = 0;
    localparam int PEND_SMI = 1;
    localparam int PEND_MCK = 2;
    localparam int PEND_RST = 3;
    localparam int NUM_PEND = 4;
    localparam int PEND_IDX_W = $clog2(NUM_PEND);

    typedef struct packed {
        logic [NUM_PEND-1:0] pend;
        logic                halt;
        logic                rst_req;
        logic                tb_start;
        logic                tb_stop;
        logic                irq;
    } act_state_t;

endpackage

// File: rtl/pinfe_sync.sv
module pinfe_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinfe_edge.sv
module pinfe_edge
    import pinfe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [W-1:0]            smp_i,
    output logic [NUM_DEF_PINS-1:0] chg_o,
    output logic [NUM_DEF_PINS-1:0] lvl_o
);
    localparam logic [W-1:0] TRACK_MASK = W'((1 << NUM_DEF_PINS) - 1);

    logic [W-1:0] rec_d, rec_q;
    logic [W-1:0] diff;

    // a sample equal to the record changes nothing; spare pins never update
    always_comb begin
        diff  = smp_i ^ rec_q;
        rec_d = rec_q ^ (diff & TRACK_MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rec_q <= '0;
        else         rec_q <= rec_d;
    end

    for (genvar g = 0; g < NUM_DEF_PINS; g++) begin : g_pin
        assign chg_o[g] = diff[g];
        assign lvl_o[g] = smp_i[g];
    end
endmodule

// File: rtl/pinfe_act.sv
module pinfe_act
    import pinfe_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_DEF_PINS-1:0] chg_i,
    input  logic [NUM_DEF_PINS-1:0] lvl_i,
    input  logic                    ack_valid_i,
    input  logic [PEND_IDX_W-1:0]   ack_idx_i,
    output act_state_t              st_o
);
    act_state_t st_d, st_q;
    logic [NUM_PEND-1:0] set_vec, drop_vec, ack_vec;

    always_comb begin
        for (int i = 0; i < NUM_PEND; i++) begin
            ack_vec[i] = ack_valid_i && (ack_idx_i == PEND_IDX_W'(i));
        end

        set_vec  = '0;
        drop_vec = '0;
        // level-following pins
        set_vec[PEND_EXT]  = chg_i[PIN_EXT]  &  lvl_i[PIN_EXT];
        drop_vec[PEND_EXT] = chg_i[PIN_EXT]  & ~lvl_i[PIN_EXT];
        set_vec[PEND_SMI]  = chg_i[PIN_SMI]  &  lvl_i[PIN_SMI];
        drop_vec[PEND_SMI] = chg_i[PIN_SMI]  & ~lvl_i[PIN_SMI];
        set_vec[PEND_RST]  = chg_i[PIN_SRST] &  lvl_i[PIN_SRST];
        drop_vec[PEND_RST] = chg_i[PIN_SRST] & ~lvl_i[PIN_SRST];
        // falling-edge capture, never dropped by the pin
        set_vec[PEND_MCK]  = chg_i[PIN_MCK]  & ~lvl_i[PIN_MCK];

        st_d          = st_q;
        st_d.pend     = (st_q.pend & ~(drop_vec | ack_vec)) | set_vec;
        st_d.halt     = st_q.halt | (chg_i[PIN_CSTOP] & lvl_i[PIN_CSTOP]);
        st_d.rst_req  = chg_i[PIN_HRST] & lvl_i[PIN_HRST];
        st_d.tb_start = chg_i[PIN_TBEN] &  lvl_i[PIN_TBEN];
        st_d.tb_stop  = chg_i[PIN_TBEN] & ~lvl_i[PIN_TBEN];
        st_d.irq      = |st_d.pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign st_o = st_q;

    AST_MCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend[PEND_MCK] && !(ack_valid_i && ack_idx_i == PEND_IDX_W'(PEND_MCK)))
        |=> st_q.pend[PEND_MCK]); // R3

    AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.halt |=> st_q.halt); // R4

    AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.rst_req |=> !st_q.rst_req); // R5

    AST_TB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.tb_start && st_q.tb_stop)); // R7

    AST_IRQ_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.irq == (st_q.pend != '0)); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_valid_i && ack_idx_i == PEND_IDX_W'(PEND_EXT)
         && !(chg_i[PIN_EXT] && lvl_i[PIN_EXT]))
        |=> !st_q.pend[PEND_EXT]); // R10
endmodule

// File: rtl/pin_irq_frontend.sv
module pin_irq_frontend
    import pinfe_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PIN_W-1:0]      pins_i,
    input  logic                  ack_valid_i,
    input  logic [PEND_IDX_W-1:0] ack_idx_i,
    output logic [NUM_PEND-1:0]   pending_o,
    output logic                  irq_req_o,
    output logic                  halt_o,
    output logic                  sys_reset_req_o,
    output logic                  tb_start_o,
    output logic                  tb_stop_o
);
    logic [PIN_W-1:0]        pins_sync;
    logic [NUM_DEF_PINS-1:0] chg, lvl;
    act_state_t              st;

    pinfe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .sync_o  (pins_sync)
    );

    pinfe_edge #(.W(PIN_W)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .smp_i  (pins_sync),
        .chg_o  (chg),
        .lvl_o  (lvl)
    );

    pinfe_act u_act (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .chg_i       (chg),
        .lvl_i       (lvl),
        .ack_valid_i (ack_valid_i),
        .ack_idx_i   (ack_idx_i),
        .st_o        (st)
    );

    assign pending_o       = st.pend;
    assign irq_req_o       = st.irq;
    assign halt_o          = st.halt;
    assign sys_reset_req_o = st.rst_req;
    assign tb_start_o      = st.tb_start;
    assign tb_stop_o       = st.tb_stop;
endmodule

// File: tb/pin_irq_frontend_test.sv
`timescale 1ns/1ps
module pin_irq_frontend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = '0;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_idx = '0;
    logic [3:0] pending;
    logic       irq_req, halt, rst_req, tb_start, tb_stop;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pin_irq_frontend uut (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
        .ack_valid_i(ack_valid), .ack_idx_i(ack_idx),
        .pending_o(pending), .irq_req_o(irq_req), .halt_o(halt),
        .sys_reset_req_o(rst_req), .tb_start_o(tb_start), .tb_stop_o(tb_stop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic one_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_pin(input int idx, input logic v);
        pins[idx] = v;
        settle();
    endtask

    task automatic do_ack(input logic [1:0] idx);
        ack_valid = 1'b1;
        ack_idx = idx;
        one_cycle();
        ack_valid = 1'b0;
    endtask

    task automatic do_reset();
        pins = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        one_cycle();
    endtask

    task automatic t_reset();
        chk("R1 pending", pending, 4'h0);
        chk("R1 irq", irq_req, 1'b0);
        chk("R1 halt", halt, 1'b0);
        chk("R1 outputs", {rst_req, tb_start, tb_stop}, 3'b000);
    endtask

    task automatic t_latency();
        pins[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet after two edges", pending, 4'h0);
        one_cycle();
        chk("R11 visible after third edge", pending, 4'h1);
        chk("R8 irq with ext", irq_req, 1'b1);
        drive_pin(0, 1'b0);
        chk("R2 ext follows low", pending, 4'h0);
    endtask

    task automatic t_level();
        drive_pin(1, 1'b1);
        chk("R2 smi high", pending, 4'h2);
        drive_pin(0, 1'b1);
        chk("R2 ext and smi", pending, 4'h3);
        drive_pin(1, 1'b0);
        chk("R2 smi low", pending, 4'h1);
        chk("R8 irq still set", irq_req, 1'b1);
        drive_pin(0, 1'b0);
        chk("R2 all low", pending, 4'h0);
        chk("R8 irq drops on empty", irq_req, 1'b0);
    endtask

    task automatic t_mck();
        drive_pin(2, 1'b1);
        chk("R3 rise ignored", pending, 4'h0);
        drive_pin(2, 1'b0);
        chk("R3 fall sets", pending, 4'h4);
        drive_pin(2, 1'b1);
        chk("R3 rise keeps bit", pending, 4'h4);
        do_ack(2'd2);
        chk("R10 ack clears mck", pending, 4'h0);
        drive_pin(2, 1'b0);
        chk("R3 second fall sets", pending, 4'h4);
        do_ack(2'd2);
        chk("R10 ack clears mck again", pending, 4'h0);
    endtask

    task automatic t_sreset();
        drive_pin(5, 1'b1);
        chk("R6 soft reset high", pending, 4'h8);
        drive_pin(5, 1'b0);
        chk("R6 soft reset low", pending, 4'h0);
    endtask

    task automatic t_hreset();
        drive_pin(4, 1'b1);
        chk("R5 request pulse", rst_req, 1'b1);
        one_cycle();
        chk("R5 request one cycle", rst_req, 1'b0);
        pins[4] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 no request on fall", rst_req, 1'b0);
        one_cycle();
        chk("R5 quiet after fall", rst_req, 1'b0);
    endtask

    task automatic t_tb();
        drive_pin(6, 1'b1);
        chk("R7 start on rise", {tb_start, tb_stop}, 2'b10);
        one_cycle();
        chk("R7 start one cycle", {tb_start, tb_stop}, 2'b00);
        drive_pin(6, 1'b0);
        chk("R7 stop on fall", {tb_start, tb_stop}, 2'b01);
        one_cycle();
        chk("R7 stop one cycle", {tb_start, tb_stop}, 2'b00);
    endtask

    task automatic t_spare();
        drive_pin(7, 1'b1);
        chk("R9 spare rise", {pending, irq_req, halt, rst_req, tb_start, tb_stop}, 9'h0);
        drive_pin(7, 1'b0);
        chk("R9 spare fall", {pending, irq_req, halt, rst_req, tb_start, tb_stop}, 9'h0);
    endtask

    task automatic t_ack_conflict();
        pins[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_idx = 2'd0;
        one_cycle();
        ack_valid = 1'b0;
        chk("R10 set wins over ack", pending, 4'h1);
        do_ack(2'd0);
        chk("R10 ack clears held level", pending, 4'h0);
        one_cycle();
        chk("R10 stays cleared while pin steady", pending, 4'h0);
        chk("R8 irq after ack", irq_req, 1'b0);
        drive_pin(0, 1'b0);
        chk("R2 fall after ack", pending, 4'h0);
    endtask

    task automatic t_halt();
        drive_pin(3, 1'b1);
        chk("R4 halt set", halt, 1'b1);
        drive_pin(3, 1'b0);
        chk("R4 halt kept on fall", halt, 1'b1);
        do_reset();
        chk("R4 halt cleared by reset", halt, 1'b0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_latency();
        t_level();
        t_mck();
        t_sreset();
        t_hreset();
        t_tb();
        t_spare();
        t_ack_conflict();
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule